// File: doc/BRIEF.md
# Bipolar Return-to-Zero Serial Line Transmitter

This block turns a stream of serial data bits into the three-level, return-to-zero line code used on avionics data buses at the high-speed rate of 100 kbit/s. Bits arrive one per push, each with its own transmit-enable flag. For example, they can come from a serial shift register fed by a host. Each bit and its flag are stored together in a small FIFO. A 1 MHz reference tick, divided by ten, paces the playback. A 32-bit bus word is four bytes pushed bit by bit, with the lowest byte first.

For each bit period the block pops one entry and produces a level code for each of the two wires of a complementary pair. The code can be positive, zero or negative. The data level is driven for the first half of the period and both wires return to zero for the second half. An entry whose enable flag is clear keeps the line at zero for its whole period. A ready flag shows that the FIFO is empty and the last bit has fully finished. A sticky flag records any push that was dropped because the FIFO was full.

Top module: `a429_rz_tx`

## Requirements
- R1: After reset both wire codes are zero (2'b00), the ready flag is 1 and the overflow flag is 0.
- R2: Each wire code is 2'b01 for positive, 2'b00 for zero and 2'b11 for negative. A driven 1 puts wire A at 2'b01 and wire B at 2'b11. A driven 0 puts A at 2'b11 and B at 2'b01. The two wires are never both nonzero with the same level.
- R3: A bit period lasts exactly ten reference ticks. One FIFO entry is popped per period, on the tick that starts it.
- R4: Within a period the data level holds for the first five ticks and both wires are zero for the last five.
- R5: An entry stored with its enable flag at 0 keeps both wires at zero for its full ten-tick period, and still uses up that period.
- R6: Bits leave in the order they were pushed, with no gap between back-to-back periods.
- R7: The ready flag is 0 whenever the FIFO holds an entry or a period is in progress. It returns to 1 only on the tick that ends the null half of the last period.
- R8: The FIFO holds 16 entries. A push while 16 entries are stored is dropped and sets the overflow flag, which stays at 1 until reset.
- R9: While the FIFO is empty and no bit is in progress, the divider is held at zero. The first bit after an idle spell starts on the next reference tick after the data is stored, not at the moment of the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 1 MHz, the reference for the bit rate |
| push_i | input | 1 | Store one bit and its enable flag |
| bit_i | input | 1 | Serial data bit |
| tx_en_i | input | 1 | Per-bit transmit enable stored with the bit |
| line_a_o | output | 2 | Level code for wire A |
| line_b_o | output | 2 | Level code for wire B |
| ready_o | output | 1 | FIFO empty and no bit in progress |
| overflow_o | output | 1 | Sticky flag for a push dropped on a full FIFO |

## Verification
A wrong divider count shows within one bit period. The null half would start on the wrong tick, or the next pop would arrive early or late, and both effects are visible on the wire codes at tick granularity. Corrupted FIFO pointers or counts show as a reordered, repeated or missing bit a few periods later. Such faults also show as a ready flag that rises before every pushed bit has been played out. A lost enable flag shows during the first half of the affected period as a drive where null was expected, or the reverse.

// File: rtl/a429_tx_pkg.sv
`timescale 1ns/1ps
package a429_tx_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_e;

  typedef struct packed {
    logic data;
    logic tx_en;
  } slot_t;
endpackage

// File: rtl/a429_bit_fifo.sv
`timescale 1ns/1ps
module a429_bit_fifo
  import a429_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  slot_t         wdata_i,
  input  logic          pop_i,
  output slot_t         rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  slot_t         mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en, rd_en;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (wr_en) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_en) rd_ptr_q <= nxt(rd_ptr_q);
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/a429_rate_div.sv
`timescale 1ns/1ps
module a429_rate_div #(
  parameter int DIV = 10,
  localparam int DCW  = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int HALF = DIV / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           start_i,
  input  logic           run_i,
  output logic           period_end_o,
  output logic           first_half_o,
  output logic [DCW-1:0] cnt_o
);
  logic [DCW-1:0] cnt_q;

  assign period_end_o = run_i && tick_i && (cnt_q == DCW'(DIV - 1));
  assign first_half_o = (cnt_q < DCW'(HALF));
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (period_end_o)      cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/a429_rz_encoder.sv
`timescale 1ns/1ps
module a429_rz_encoder
  import a429_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  slot_t      slot_i,
  input  logic       period_end_i,
  input  logic       first_half_i,
  output logic       active_o,
  output logic [1:0] line_a_o,
  output logic [1:0] line_b_o
);
  slot_t      cur_q;
  logic       drive;
  logic [1:0] lvl [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cur_q    <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      cur_q    <= slot_i;
    end else if (period_end_i) begin
      active_o <= 1'b0;
    end
  end

  assign drive = active_o && cur_q.tx_en && first_half_i;

  // wire 0 (A) is positive on a 1, wire 1 (B) is its complement
  for (genvar g = 0; g < 2; g++) begin : g_wire
    localparam logic INV = (g == 1);
    always_comb begin
      if (!drive)                  lvl[g] = LVL_ZERO;
      else if (cur_q.data ^ INV)   lvl[g] = LVL_POS;
      else                         lvl[g] = LVL_NEG;
    end
  end

  assign line_a_o = lvl[0];
  assign line_b_o = lvl[1];
endmodule

// File: rtl/a429_rz_tx.sv
`timescale 1ns/1ps
module a429_rz_tx
  import a429_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       push_i,
  input  logic       bit_i,
  input  logic       tx_en_i,
  output logic [1:0] line_a_o,
  output logic [1:0] line_b_o,
  output logic       ready_o,
  output logic       overflow_o
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  slot_t          wslot, rslot;
  logic           fifo_empty, fifo_full;
  logic [CW-1:0]  fifo_cnt;
  logic           active, period_end, first_half, pop;
  logic [DCW-1:0] div_cnt;

  assign wslot = '{data: bit_i, tx_en: tx_en_i};
  // pop on a tick, either from idle or at the boundary of the running period
  assign pop   = tick_i && !fifo_empty && (!active || period_end);
  assign ready_o = fifo_empty && !active;

  a429_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .wdata_i (wslot),
    .pop_i   (pop),
    .rdata_o (rslot),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .count_o (fifo_cnt),
    .ovf_o   (overflow_o)
  );

  a429_rate_div #(.DIV(DIV)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .start_i      (pop),
    .run_i        (active),
    .period_end_o (period_end),
    .first_half_o (first_half),
    .cnt_o        (div_cnt)
  );

  a429_rz_encoder u_enc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (pop),
    .slot_i       (rslot),
    .period_end_i (period_end),
    .first_half_i (first_half),
    .active_o     (active),
    .line_a_o     (line_a_o),
    .line_b_o     (line_b_o)
  );
endmodule

// File: rtl/a429_rz_tx_chk.sv
`timescale 1ns/1ps
module a429_rz_tx_chk #(
  parameter int DEPTH = 16,
  parameter int DIV   = 10,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           push_i,
  input logic [1:0]     line_a_i,
  input logic [1:0]     line_b_i,
  input logic           ready_i,
  input logic           overflow_i,
  input logic           fifo_full_i,
  input logic           fifo_empty_i,
  input logic [CW-1:0]  fifo_cnt_i,
  input logic [DCW-1:0] div_cnt_i,
  input logic           active_i
);
  AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_a_i != 2'b10 && line_b_i != 2'b10); // R2
  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_a_i != 2'b00 |-> (line_b_i != 2'b00 && line_b_i != line_a_i)); // R2
  AST_NULL_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_a_i == 2'b00 |-> line_b_i == 2'b00); // R2
  AST_NULL_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt_i >= DCW'(DIV / 2) |-> (line_a_i == 2'b00 && line_b_i == 2'b00)); // R4
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (line_a_i == 2'b00 && line_b_i == 2'b00)); // R7
  AST_READY_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_empty_i || active_i) |-> !ready_i); // R7
  AST_NO_OVERFLOW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && fifo_full_i |=> overflow_i); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_i |=> overflow_i); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH)); // R8
  AST_DIV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> div_cnt_i == '0); // R9
endmodule

bind a429_rz_tx a429_rz_tx_chk #(.DEPTH(DEPTH), .DIV(DIV)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .line_a_i     (line_a_o),
  .line_b_i     (line_b_o),
  .ready_i      (ready_o),
  .overflow_i   (overflow_o),
  .fifo_full_i  (fifo_full),
  .fifo_empty_i (fifo_empty),
  .fifo_cnt_i   (fifo_cnt),
  .div_cnt_i    (div_cnt),
  .active_i     (active)
);

// File: tb/a429_rz_tx_tb_top.sv
`timescale 1ns/1ps
module a429_rz_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       push_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       tx_en_i = 1'b0;
  logic [1:0] line_a_o, line_b_o;
  logic       ready_o, overflow_o;

  int checks = 0;
  int errors = 0;
  int tick_div = 0;
  logic q_bit [32];
  logic q_en  [32];
  int   q_n = 0;

  a429_rz_tx dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .push_i     (push_i),
    .bit_i      (bit_i),
    .tx_en_i    (tx_en_i),
    .line_a_o   (line_a_o),
    .line_b_o   (line_b_o),
    .ready_o    (ready_o),
    .overflow_o (overflow_o)
  );

  always #10 clk_i = ~clk_i;

  // 1 MHz tick from the 50 MHz clock
  always @(negedge clk_i) begin
    if (tick_div == 49) begin
      tick_div <= 0;
      tick_i   <= 1'b1;
    end else begin
      tick_div <= tick_div + 1;
      tick_i   <= 1'b0;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic next_tick();
    do @(posedge clk_i); while (!tick_i);
    @(negedge clk_i);
  endtask

  task automatic push_one(input logic b, input logic e, input bit keep);
    @(negedge clk_i);
    push_i = 1'b1; bit_i = b; tx_en_i = e;
    @(negedge clk_i);
    push_i = 1'b0;
    if (keep) begin
      q_bit[q_n] = b; q_en[q_n] = e; q_n++;
    end
  endtask

  // play back the queued model, sampled after every tick
  task automatic play(input string tag);
    for (int i = 0; i < q_n; i++) begin
      for (int k = 0; k < 10; k++) begin
        logic drv;
        logic [1:0] ea, eb;
        next_tick();
        drv = q_en[i] && (k < 5);
        ea = !drv ? 2'b00 : (q_bit[i] ? 2'b01 : 2'b11);
        eb = !drv ? 2'b00 : (q_bit[i] ? 2'b11 : 2'b01);
        chk(tag, $sformatf("bit %0d tick %0d wire A", i, k), 32'(line_a_o), 32'(ea));
        chk(tag, $sformatf("bit %0d tick %0d wire B", i, k), 32'(line_b_o), 32'(eb));
        chk("R7", $sformatf("bit %0d tick %0d ready", i, k), 32'(ready_o), 32'd0);
      end
    end
    next_tick();
    chk("R7", "ready after last null half", 32'(ready_o), 32'd1);
    chk("R7", "idle wire A", 32'(line_a_o), 32'd0);
    chk("R7", "idle wire B", 32'(line_b_o), 32'd0);
    q_n = 0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", "reset wire A", 32'(line_a_o), 32'd0);
    chk("R1", "reset wire B", 32'(line_b_o), 32'd0);
    chk("R1", "reset ready", 32'(ready_o), 32'd1);
    chk("R1", "reset overflow", 32'(overflow_o), 32'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_basic();
    next_tick();
    push_one(1'b1, 1'b1, 1'b1);
    push_one(1'b0, 1'b1, 1'b1);
    push_one(1'b1, 1'b1, 1'b1);
    push_one(1'b1, 1'b1, 1'b1);
    push_one(1'b0, 1'b1, 1'b1);
    play("R2 R3 R4 R6");
  endtask

  task automatic t_enable();
    next_tick();
    push_one(1'b1, 1'b0, 1'b1);
    push_one(1'b0, 1'b1, 1'b1);
    push_one(1'b0, 1'b0, 1'b1);
    push_one(1'b1, 1'b1, 1'b1);
    play("R5 R3");
  endtask

  task automatic t_idle_start();
    next_tick();
    repeat (20) @(negedge clk_i);
    push_one(1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk_i);
    chk("R9", "no drive before next tick A", 32'(line_a_o), 32'd0);
    chk("R9", "no drive before next tick B", 32'(line_b_o), 32'd0);
    chk("R7", "ready low once data stored", 32'(ready_o), 32'd0);
    play("R9 R4");
  endtask

  task automatic t_overflow();
    next_tick();
    for (int i = 0; i < 16; i++) push_one(1'(i % 3 == 0), 1'b1, 1'b1);
    chk("R8", "no overflow at 16 entries", 32'(overflow_o), 32'd0);
    push_one(1'b0, 1'b1, 1'b0);
    chk("R8", "overflow after 17th push", 32'(overflow_o), 32'd1);
    play("R8 R6");
    chk("R8", "overflow still set", 32'(overflow_o), 32'd1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_enable();
    t_idle_start();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule